// File: doc/BRIEF.md
# Slotted Broadcast Status Exchange Node

This block lives in every I/O node attached to a shared, daisy-chained broadcast bus. At the start of each control cycle a host broadcasts a query. Each node answers after a delay proportional to its own node number, so answers never collide. It broadcasts its local status record in that slot. Every node also listens to the status answers of all other nodes and keeps them in a table. The host therefore needs to read only one node to see the state of the whole bus. The host then broadcasts one command packet that carries a slice for every node. Each node keeps only the slice that its node number selects.

Packets reach the block as a word stream with valid, start and end markers, and leave it as a valid/ready word stream with the same markers. Word 0 of every packet is a header. Its two top bits carry the packet kind: 0 query, 1 status, 2 command, 3 reserved. Its low eight bits carry the sender number. A status packet carries K payload words after the header. A command packet carries N·K payload words: node 0's K words first, then node 1's, and so on. Timing uses a free-running prescaler that produces one tick per microsecond from `CLK_PER_US` clock cycles.

The transmitter has four states. TX_IDLE goes to TX_WAIT on a query. TX_WAIT goes to TX_SEND when its down-counter reaches zero. TX_SEND goes back to TX_IDLE after the last word is accepted. TX_SEND goes to TX_CLOSE when a query arrives after the packet has started, and to TX_WAIT when a query arrives before the packet has started. TX_CLOSE goes to TX_WAIT once its closing word is accepted. Any query reloads the counter.

The receiver also has four states. RX_IDLE decodes each header. It moves to RX_STATUS or RX_CMD when the header carries a payload. It moves to RX_SKIP for a reserved or over-long query packet. Every state returns to RX_IDLE on an end marker, and any header restarts the decode.

Top module: `slot_status_node`

## Requirements
- R1: After a query header is accepted at clock edge E0, node n presents the first word of its status packet as follows. For n = 0 it appears one cycle after E0. For n > 0 the latency L, in cycles after E0, satisfies (5n−1)·CLK_PER_US+2 ≤ L ≤ 5n·CLK_PER_US+1. This is because the node waits 5·n microsecond ticks of the free-running prescaler.
- R2: The status packet is one header followed by K words, with start marked on the header and end marked on word K. The header has kind 1 in bits [DW−1:DW−2] and the node number in bits [7:0]. Payload word k is bits [k·DW +: DW] of `local_status`, sampled when the header is first presented.
- R3: While `tx_valid` is high and `tx_ready` is low, the presented word and its markers stay unchanged.
- R4: A status packet from sender j, where j < N and j differs from the own number, is stored in table entry j only if it has exactly K payload words. Entry j is `table_data[j·K·DW +: K·DW]`, payload word 0 goes in the low bits, and the store sets `table_valid[j]`.
- R5: When the node starts its own transmission, it writes its sampled record into its own table entry and sets its valid bit.
- R6: All valid bits are zero after reset, and all of them clear in the cycle after any query header.
- R7: For a command packet with exactly N·K payload words, `cmd_strobe` pulses for one cycle after the end word. `cmd_data` then holds payload words n·K … n·K+K−1, with word n·K in the low bits. `cmd_data` is unchanged at all other times.
- R8: A status or command packet is malformed if its payload count is not the expected one, or if a new header interrupts it. A malformed packet changes neither the table nor `cmd_data` nor `cmd_strobe`, and it raises `rx_fault` for one cycle.
- R9: A query during TX_WAIT reloads the slot wait from the new query. A query after the status header has been accepted ends the packet with one extra word of value 0 that carries the end marker. The node then waits out the new slot and sends a fresh packet.
- R10: Status packets that carry the node's own number, or a number of N or more, are ignored and raise no fault.
- R11: Packets of the reserved kind 3 are ignored: there is no table change, no command strobe and no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | IDW | This node's number, 0 … N−1 |
| local_status | input | K·DW | Local status record, word 0 in the low bits |
| rx_valid | input | 1 | Received word present |
| rx_data | input | DW | Received word |
| rx_sop | input | 1 | Received word is a header |
| rx_eop | input | 1 | Received word ends the packet |
| tx_ready | input | 1 | Bus accepts the presented word |
| tx_valid | output | 1 | A transmit word is presented |
| tx_data | output | DW | Transmit word |
| tx_sop | output | 1 | Transmit word is a header |
| tx_eop | output | 1 | Transmit word ends the packet |
| table_data | output | N·K·DW | Status of all nodes, entry j at [j·K·DW +: K·DW] |
| table_valid | output | N | Entry holds data from the current cycle |
| cmd_data | output | K·DW | This node's command slice |
| cmd_strobe | output | 1 | One-cycle pulse when a new command slice is taken |
| rx_fault | output | 1 | One-cycle pulse on a malformed packet |

## Verification
The hardest situation to reach from the ports is a query that lands in the middle of the node's own transmission. Here the header has already been taken but the payload has not, and the bus must end up with a cleanly closed packet. The bench reaches it by accepting exactly one word under `tx_ready` and then holding `tx_ready` low. It injects a query while the payload word is stalled, and then expects the zero closing word with the end marker before a fresh slot begins. Slot timing is checked against an arithmetic window for every node number, because the prescaler phase is not visible at the ports. The sweep also covers a re-query during the wait.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    // header kind field, top two bits of word 0
    typedef enum logic [1:0] {
        PK_QUERY  = 2'd0,
        PK_STATUS = 2'd1,
        PK_CMD    = 2'd2,
        PK_RSVD   = 2'd3
    } pkt_kind_e;

    // sender number occupies the low bits of word 0
    localparam int ID_FIELD_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_SEND,
        TX_CLOSE
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_STATUS,
        RX_CMD,
        RX_SKIP
    } rx_state_e;

endpackage

// File: rtl/ssx_us_tick.sv
module ssx_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (pre_q == LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == LAST);

endmodule

// File: rtl/ssx_slot_tx.sv
module ssx_slot_tx
    import ssx_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int WORDS   = 2,
    parameter int DW      = 16,
    parameter int SLOT_US = 5,
    parameter int IDW     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  query,
    input  logic [IDW-1:0]        node_id,
    input  logic [WORDS*DW-1:0]   local_status,
    input  logic                  tx_ready,
    output logic                  tx_valid,
    output logic [DW-1:0]         tx_data,
    output logic                  tx_sop,
    output logic                  tx_eop,
    output logic                  own_wr
);
    localparam int WW = $clog2(SLOT_US * NODES + 1);
    localparam int XW = $clog2(WORDS + 1);
    localparam logic [XW-1:0] LAST_IDX = XW'(WORDS);

    tx_state_e            st_q, st_d;
    logic [WW-1:0]        cnt_q;
    logic [XW-1:0]        widx_q;
    logic [WORDS*DW-1:0]  snap_q;
    logic                 hs, last_word, started;
    logic [WW-1:0]        load_val;
    logic [XW-1:0]        sel;
    logic [DW-1:0]        hdr;

    assign hs        = tx_valid && tx_ready;
    assign last_word = (widx_q == LAST_IDX);
    assign started   = (widx_q != '0) || tx_ready;
    assign load_val  = WW'(SLOT_US * int'(node_id));

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: begin
                if (query) st_d = TX_WAIT;
            end
            TX_WAIT: begin
                if (query)             st_d = TX_WAIT;
                else if (cnt_q == '0)  st_d = TX_SEND;
            end
            TX_SEND: begin
                if (query) begin
                    if (tx_ready && last_word) st_d = TX_WAIT;
                    else if (started)          st_d = TX_CLOSE;
                    else                       st_d = TX_WAIT;
                end else if (hs && last_word) begin
                    st_d = TX_IDLE;
                end
            end
            TX_CLOSE: begin
                if (tx_ready) st_d = TX_WAIT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // slot counter, word index and record snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            widx_q <= '0;
            snap_q <= '0;
        end else begin
            if (query)
                cnt_q <= load_val;
            else if ((st_q == TX_WAIT || st_q == TX_CLOSE) && tick && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;

            if (st_q != TX_SEND || st_d != TX_SEND)
                widx_q <= '0;
            else if (hs)
                widx_q <= widx_q + 1'b1;

            if (st_q == TX_WAIT && st_d == TX_SEND)
                snap_q <= local_status;
        end
    end

    // outputs
    always_comb begin
        hdr = '0;
        hdr[DW-1 -: 2] = PK_STATUS;
        hdr[ID_FIELD_W-1:0] = ID_FIELD_W'(node_id);
        sel = (widx_q == '0) ? '0 : widx_q - 1'b1;

        tx_valid = (st_q == TX_SEND) || (st_q == TX_CLOSE);
        tx_sop   = (st_q == TX_SEND) && (widx_q == '0);
        tx_eop   = ((st_q == TX_SEND) && last_word) || (st_q == TX_CLOSE);
        if (st_q == TX_SEND)
            tx_data = (widx_q == '0) ? hdr : snap_q[int'(sel)*DW +: DW];
        else
            tx_data = '0;
        own_wr = (st_q == TX_WAIT) && (st_d == TX_SEND);
    end

    // a stalled word must not change unless a query forces the close path
    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !query) |=> (tx_valid && $stable(tx_data) && $stable(tx_eop)));

    // after an accepted end word the transmitter falls quiet for at least one cycle
    assert_quiet_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eop && !query) |=> !tx_valid);

    // a start marker is never shown while the slot counter still runs
    assert_no_early_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_WAIT && cnt_q > WW'(1)) |=> !tx_sop);

endmodule

// File: rtl/ssx_rx_parse.sv
module ssx_rx_parse
    import ssx_pkg::*;
#(
    parameter int NODES = 4,
    parameter int WORDS = 2,
    parameter int DW    = 16,
    parameter int IDW   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDW-1:0]        node_id,
    input  logic                  rx_valid,
    input  logic [DW-1:0]         rx_data,
    input  logic                  rx_sop,
    input  logic                  rx_eop,
    output logic                  query,
    output logic                  st_wr,
    output logic [IDW-1:0]        st_id,
    output logic [WORDS*DW-1:0]   st_data,
    output logic                  cmd_strobe,
    output logic [WORDS*DW-1:0]   cmd_data,
    output logic                  rx_fault
);
    localparam int PLEN = NODES * WORDS;
    localparam int CW   = $clog2(PLEN + 2);
    localparam logic [CW-1:0] CNT_SAT = CW'(PLEN + 1);

    rx_state_e              rs_q, rs_d;
    pkt_kind_e              kind;
    logic [CW-1:0]          cnt_q;
    logic [ID_FIELD_W-1:0]  pid_q;
    logic [WORDS*DW-1:0]    sbuf_q, cbuf_q, sfull, cfull;
    logic [CW-1:0]          base;
    logic                   is_hdr, mid, in_pkt;
    logic                   stat_ok, cmd_ok, fault_d;

    assign kind   = pkt_kind_e'(rx_data[DW-1 -: 2]);
    assign is_hdr = rx_valid && rx_sop;
    assign mid    = rx_valid && !rx_sop;
    assign in_pkt = (rs_q == RX_STATUS) || (rs_q == RX_CMD);
    assign query  = is_hdr && (kind == PK_QUERY);
    assign base   = CW'(int'(node_id) * WORDS);

    // merged buffers: stored words plus the word arriving now
    for (genvar k = 0; k < WORDS; k++) begin : g_merge
        assign sfull[k*DW +: DW] = (cnt_q == CW'(k)) ? rx_data : sbuf_q[k*DW +: DW];
        assign cfull[k*DW +: DW] = (cnt_q == base + CW'(k)) ? rx_data : cbuf_q[k*DW +: DW];
    end

    // next state
    always_comb begin
        rs_d = rs_q;
        if (is_hdr) begin
            unique case (kind)
                PK_QUERY:  rs_d = rx_eop ? RX_IDLE : RX_SKIP;
                PK_STATUS: rs_d = rx_eop ? RX_IDLE : RX_STATUS;
                PK_CMD:    rs_d = rx_eop ? RX_IDLE : RX_CMD;
                PK_RSVD:   rs_d = rx_eop ? RX_IDLE : RX_SKIP;
            endcase
        end else if (mid && rx_eop) begin
            rs_d = RX_IDLE;
        end
    end

    always_comb begin
        stat_ok = mid && rx_eop && (rs_q == RX_STATUS) && (cnt_q == CW'(WORDS - 1))
                  && (int'(pid_q) < NODES) && (pid_q != ID_FIELD_W'(node_id));
        cmd_ok  = mid && rx_eop && (rs_q == RX_CMD) && (cnt_q == CW'(PLEN - 1));
        fault_d = (is_hdr && in_pkt)
               || (is_hdr && rx_eop && (kind == PK_STATUS || kind == PK_CMD))
               || (mid && rx_eop && (rs_q == RX_STATUS) && (cnt_q != CW'(WORDS - 1)))
               || (mid && rx_eop && (rs_q == RX_CMD) && (cnt_q != CW'(PLEN - 1)));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= RX_IDLE;
        else        rs_q <= rs_d;
    end

    // payload counting and buffering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pid_q  <= '0;
            sbuf_q <= '0;
            cbuf_q <= '0;
        end else begin
            if (is_hdr) begin
                cnt_q <= '0;
                pid_q <= rx_data[ID_FIELD_W-1:0];
            end else if (mid && cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (mid && rs_q == RX_STATUS) sbuf_q <= sfull;
            if (mid && rs_q == RX_CMD)    cbuf_q <= cfull;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_wr      <= 1'b0;
            st_id      <= '0;
            st_data    <= '0;
            cmd_strobe <= 1'b0;
            cmd_data   <= '0;
            rx_fault   <= 1'b0;
        end else begin
            st_wr      <= stat_ok;
            st_id      <= pid_q[IDW-1:0];
            st_data    <= sfull;
            cmd_strobe <= cmd_ok;
            if (cmd_ok) cmd_data <= cfull;
            rx_fault   <= fault_d;
        end
    end

    assert_strobe_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $past(rx_valid && rx_eop && !rx_sop));

    assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |-> $stable(cmd_data));

    assert_fault_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fault |-> (!cmd_strobe && !st_wr));

endmodule

// File: rtl/ssx_status_table.sv
module ssx_status_table #(
    parameter int NODES = 4,
    parameter int WORDS = 2,
    parameter int DW    = 16,
    parameter int IDW   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wa_en,
    input  logic [IDW-1:0]              wa_id,
    input  logic [WORDS*DW-1:0]         wa_data,
    input  logic                        wb_en,
    input  logic [IDW-1:0]              wb_id,
    input  logic [WORDS*DW-1:0]         wb_data,
    output logic [NODES*WORDS*DW-1:0]   tbl_data,
    output logic [NODES-1:0]            tbl_valid
);
    localparam int EW = WORDS * DW;

    for (genvar i = 0; i < NODES; i++) begin : g_entry
        logic hit_a, hit_b;
        assign hit_a = wa_en && (wa_id == IDW'(i));
        assign hit_b = wb_en && (wb_id == IDW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_valid[i]          <= 1'b0;
                tbl_data[i*EW +: EW]  <= '0;
            end else begin
                if (clr)
                    tbl_valid[i] <= 1'b0;
                else if (hit_a || hit_b)
                    tbl_valid[i] <= 1'b1;
                if (hit_a)
                    tbl_data[i*EW +: EW] <= wa_data;
                else if (hit_b)
                    tbl_data[i*EW +: EW] <= wb_data;
            end
        end
    end

    assert_query_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tbl_valid == '0));

    assert_own_entry_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !clr) |=> tbl_valid[$past(wb_id)]);

endmodule

// File: rtl/slot_status_node.sv
module slot_status_node
    import ssx_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int WORDS      = 2,
    parameter int DW         = 16,
    parameter int CLK_PER_US = 50,
    parameter int SLOT_US    = 5,
    localparam int IDW       = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDW-1:0]             node_id,
    input  logic [WORDS*DW-1:0]        local_status,
    input  logic                       rx_valid,
    input  logic [DW-1:0]              rx_data,
    input  logic                       rx_sop,
    input  logic                       rx_eop,
    input  logic                       tx_ready,
    output logic                       tx_valid,
    output logic [DW-1:0]              tx_data,
    output logic                       tx_sop,
    output logic                       tx_eop,
    output logic [NODES*WORDS*DW-1:0]  table_data,
    output logic [NODES-1:0]           table_valid,
    output logic [WORDS*DW-1:0]        cmd_data,
    output logic                       cmd_strobe,
    output logic                       rx_fault
);
    logic                 tick, query, st_wr, own_wr;
    logic [IDW-1:0]       st_id;
    logic [WORDS*DW-1:0]  st_data;

    ssx_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ssx_rx_parse #(.NODES(NODES), .WORDS(WORDS), .DW(DW), .IDW(IDW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .node_id    (node_id),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sop     (rx_sop),
        .rx_eop     (rx_eop),
        .query      (query),
        .st_wr      (st_wr),
        .st_id      (st_id),
        .st_data    (st_data),
        .cmd_strobe (cmd_strobe),
        .cmd_data   (cmd_data),
        .rx_fault   (rx_fault)
    );

    ssx_slot_tx #(.NODES(NODES), .WORDS(WORDS), .DW(DW), .SLOT_US(SLOT_US), .IDW(IDW)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .query        (query),
        .node_id      (node_id),
        .local_status (local_status),
        .tx_ready     (tx_ready),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_sop       (tx_sop),
        .tx_eop       (tx_eop),
        .own_wr       (own_wr)
    );

    ssx_status_table #(.NODES(NODES), .WORDS(WORDS), .DW(DW), .IDW(IDW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (query),
        .wa_en     (st_wr),
        .wa_id     (st_id),
        .wa_data   (st_data),
        .wb_en     (own_wr),
        .wb_id     (node_id),
        .wb_data   (local_status),
        .tbl_data  (table_data),
        .tbl_valid (table_valid)
    );

    // a command slice and a fault never appear together
    assert_strobe_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_strobe && rx_fault));

    // the own entry never goes valid without a transmission starting
    assert_own_valid_from_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(table_valid[node_id]) |-> $past(own_wr));

endmodule

// File: tb/slot_status_node_tb.sv
module slot_status_node_tb;
    localparam int N   = 4;
    localparam int K   = 2;
    localparam int DW  = 16;
    localparam int C   = 50;
    localparam int S   = 5;
    localparam int IDW = 2;
    localparam int EW  = K * DW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDW-1:0]    node_id = '0;
    logic [EW-1:0]     local_status = '0;
    logic              rx_valid = 1'b0;
    logic [DW-1:0]     rx_data = '0;
    logic              rx_sop = 1'b0;
    logic              rx_eop = 1'b0;
    logic              tx_ready = 1'b1;
    logic              tx_valid, tx_sop, tx_eop, cmd_strobe, rx_fault;
    logic [DW-1:0]     tx_data;
    logic [N*EW-1:0]   table_data;
    logic [N-1:0]      table_valid;
    logic [EW-1:0]     cmd_data;

    int total = 0;
    int bad = 0;
    int strobe_cnt = 0;
    int fault_cnt = 0;
    bit finished = 0;

    slot_status_node #(.NODES(N), .WORDS(K), .DW(DW), .CLK_PER_US(C), .SLOT_US(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .local_status(local_status),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .table_data(table_data), .table_valid(table_valid),
        .cmd_data(cmd_data), .cmd_strobe(cmd_strobe), .rx_fault(rx_fault)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n && cmd_strobe) strobe_cnt++;
        if (rst_n && rx_fault)   fault_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] hdr(input int kind, input int id);
        hdr = '0;
        hdr[DW-1 -: 2] = 2'(kind);
        hdr[7:0] = 8'(id);
    endfunction

    function automatic logic [DW-1:0] pat(input int id, input int k, input int salt);
        pat = 16'(id * 256 + k * 16 + salt);
    endfunction

    function automatic logic [EW-1:0] rec(input int id, input int salt);
        for (int k = 0; k < K; k++) rec[k*DW +: DW] = pat(id, k, salt);
    endfunction

    function automatic logic [DW-1:0] cw(input int p, input int salt);
        cw = 16'(16'hC000 + p * 16 + salt);
    endfunction

    // called at a negedge; returns at the negedge after the word is taken
    task automatic rx_word(input logic [DW-1:0] d, input bit s, input bit e);
        rx_valid = 1'b1; rx_data = d; rx_sop = s; rx_eop = e;
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    task automatic send_query();
        rx_word(hdr(0, 0), 1'b1, 1'b1);
    endtask

    task automatic send_status(input int id, input int nw, input int salt);
        rx_word(hdr(1, id), 1'b1, nw == 0);
        for (int k = 0; k < nw; k++) rx_word(pat(id, k, salt), 1'b0, k == nw - 1);
    endtask

    task automatic send_cmd(input int kind, input int nw, input int salt);
        rx_word(hdr(kind, 0), 1'b1, nw == 0);
        for (int p = 0; p < nw; p++) rx_word(cw(p, salt), 1'b0, p == nw - 1);
    endtask

    task automatic wait_tx(output int lat);
        lat = 0;
        while (!tx_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_lat(input int n, input int lat, input string req);
        int lo, hi;
        lo = (n == 0) ? 1 : (S * n - 1) * C + 2;
        hi = (n == 0) ? 1 : S * n * C + 1;
        check(lat >= lo && lat <= hi, req, 64'(lat), 64'(hi));
    endtask

    // collect a full status packet with tx_ready high
    task automatic collect(input int n, input logic [EW-1:0] exp_rec);
        for (int i = 0; i <= K; i++) begin
            logic [DW-1:0] ew;
            ew = (i == 0) ? hdr(1, n) : exp_rec[(i-1)*DW +: DW];
            check(tx_valid && tx_sop == (i == 0) && tx_eop == (i == K) && tx_data == ew,
                  "R2 status word", {tx_valid, tx_sop, tx_eop, tx_data}, {1'b1, i == 0, i == K, ew});
            @(negedge clk);
        end
        check(!tx_valid, "R2 quiet after packet", 64'(tx_valid), 64'd0);
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        summary();
    end

    initial begin
        int lat, s0, f0;
        logic [EW-1:0] cd_exp, old;
        for (int n = 0; n < N; n++) begin
            rst_n = 1'b0;
            node_id = IDW'(n);
            tx_ready = 1'b1;
            local_status = rec(n, 10);
            idle(3);
            rst_n = 1'b1;
            idle(1);
            check(!tx_valid && table_valid == '0 && !cmd_strobe && !rx_fault, "R6 reset state",
                  {tx_valid, table_valid, cmd_strobe, rx_fault}, 64'd0);

            // R1 slot timing, R2 format
            send_query();
            wait_tx(lat);
            check_lat(n, lat, "R1 slot latency");
            collect(n, rec(n, 10));
            // R5 own entry
            check(table_valid[n] && table_data[n*EW +: EW] == rec(n, 10), "R5 own entry",
                  {table_valid[n], table_data[n*EW +: EW]}, {1'b1, rec(n, 10)});

            // R4 foreign entries
            f0 = fault_cnt;
            for (int j = 0; j < N; j++) if (j != n) send_status(j, K, j + 3);
            idle(2);
            for (int j = 0; j < N; j++) begin
                if (j != n)
                    check(table_valid[j] && table_data[j*EW +: EW] == rec(j, j + 3), "R4 stored entry",
                          {table_valid[j], table_data[j*EW +: EW]}, {1'b1, rec(j, j + 3)});
            end

            // R10 own number and out-of-range number ignored
            send_status(n, K, 7'h77);
            send_status(N + 1, K, 5);
            idle(2);
            check(table_data[n*EW +: EW] == rec(n, 10) && table_valid == {N{1'b1}}, "R10 ignored status",
                  table_data[n*EW +: EW], rec(n, 10));
            check(fault_cnt == f0, "R10 no fault", 64'(fault_cnt - f0), 64'd0);

            // R7 command extraction
            s0 = strobe_cnt;
            for (int j = 0; j < K; j++) cd_exp[j*DW +: DW] = cw(n * K + j, n + 1);
            send_cmd(2, N * K, n + 1);
            check(cmd_strobe && cmd_data == cd_exp, "R7 command slice", cmd_data, cd_exp);
            idle(1);
            check(!cmd_strobe && strobe_cnt == s0 + 1, "R7 single strobe", 64'(strobe_cnt - s0), 64'd1);

            // R8 malformed packets
            f0 = fault_cnt;
            s0 = strobe_cnt;
            send_cmd(2, N * K - 1, 9);
            check(rx_fault && !cmd_strobe, "R8 short command fault", {rx_fault, cmd_strobe}, 2'b10);
            send_cmd(2, N * K + 1, 9);
            check(rx_fault, "R8 long command fault", 64'(rx_fault), 64'd1);
            idle(1);
            check(cmd_data == cd_exp && strobe_cnt == s0, "R8 command unchanged", cmd_data, cd_exp);
            old = table_data[((n+1)%N)*EW +: EW];
            send_status((n + 1) % N, 1, 8'h99);
            check(rx_fault, "R8 short status fault", 64'(rx_fault), 64'd1);
            rx_word(hdr(1, (n + 2) % N), 1'b1, 1'b0);
            rx_word(pat(0, 0, 1), 1'b0, 1'b0);
            send_status((n + 3) % N, K, 0); // interrupts the open packet
            idle(2);
            check(table_data[((n+1)%N)*EW +: EW] == old, "R8 entry unchanged", table_data[((n+1)%N)*EW +: EW], old);
            check(fault_cnt == f0 + 4, "R8 fault count", 64'(fault_cnt - f0), 64'd4);

            // R11 reserved kind
            f0 = fault_cnt;
            s0 = strobe_cnt;
            old = table_data[((n+1)%N)*EW +: EW];
            send_cmd(3, 3, 2);
            idle(2);
            check(fault_cnt == f0 && strobe_cnt == s0 && table_valid == {N{1'b1}}
                  && table_data[((n+1)%N)*EW +: EW] == old, "R11 reserved ignored",
                  64'(fault_cnt - f0 + strobe_cnt - s0), 64'd0);

            // R6 query clears, then a new cycle with new status
            local_status = rec(n, 12);
            send_query();
            check(table_valid == '0, "R6 clear on query", 64'(table_valid), 64'd0);
            wait_tx(lat);
            check_lat(n, lat, "R1 second cycle latency");
            collect(n, rec(n, 12));

            // R3 backpressure
            send_query();
            wait_tx(lat);
            tx_ready = 1'b0;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                check(tx_valid && tx_sop && tx_data == hdr(1, n), "R3 hold under stall", tx_data, hdr(1, n));
            end
            tx_ready = 1'b1;
            collect(n, rec(n, 12));

            // R9 re-query during wait
            if (n > 0) begin
                send_query();
                idle(100);
                check(!tx_valid, "R9 still waiting", 64'(tx_valid), 64'd0);
                send_query();
                wait_tx(lat);
                check_lat(n, lat, "R9 reload latency");
                collect(n, rec(n, 12));
            end

            // R9 query after header accepted
            send_query();
            wait_tx(lat);
            @(negedge clk);
            tx_ready = 1'b0;
            send_query();
            check(tx_valid && tx_eop && !tx_sop && tx_data == '0, "R9 closing word",
                  {tx_valid, tx_eop, tx_sop, tx_data}, {3'b110, 16'h0});
            tx_ready = 1'b1;
            @(negedge clk);
            wait_tx(lat);
            check(tx_sop && tx_data == hdr(1, n), "R9 fresh packet", tx_data, hdr(1, n));
            collect(n, rec(n, 12));
        end
        summary();
    end
endmodule